// File: doc/BRIEF.md
# Four-World APB Protection Filter

This block sits on an APB link between a requester that marks each transfer with a physical address space and a completer that has no access control of its own. A transfer's space comes from two bits: the extension bit `s_pnse` and the non-secure bit `s_pprot[1]`. Together they select Secure, Non-secure, Root or Realm. The top bits of the address select a region. Each region has a four-bit allow mask, so every region can admit any subset of the four spaces.

An admitted transfer is connected straight through to the completer with no added cycles. A refused transfer never reaches the completer. The filter finishes that transfer itself in its first access cycle and returns an error with zero read data. It also records the address and space of the first refused transfer in a sticky record, which only reset clears. A requester that has no address-space extension is connected by tying `s_pnse` low. The filter then acts as a plain secure/non-secure gate.

A small state machine tracks each transfer. The decision is made in the setup cycle and kept in the state until the transfer ends. The three states are:
- IDLE: no transfer in progress, or a setup cycle.
- FWD: an admitted transfer is being forwarded.
- BLK: a refused transfer is being answered locally.

The transitions are:
- IDLE→FWD on an admitted setup.
- IDLE→BLK on a refused setup.
- FWD→IDLE when the completer signals ready in an access cycle, or when select drops.
- BLK→IDLE on the access cycle, or when select drops.

Top module: `apb_world_gate`

## Requirements
- R1: The space code is {s_pnse, s_pprot[1]}: 2'b00 Secure, 2'b01 Non-secure, 2'b10 Root, 2'b11 Realm. `viol_space` reports this code.
- R2: The region is s_paddr[ADDR_W-1 -: REGION_BITS]. The allow mask of region r is allow_map[4r+3:4r], and bit k of that mask admits the space with code k. Changes to allow_map apply to the next transfer.
- R3: For an admitted transfer, m_psel follows s_psel starting in the setup cycle, and m_penable follows s_penable. m_paddr, m_pwrite, m_pwdata and m_pprot equal the upstream values. In access cycles, s_pready and s_prdata come from the completer in the same cycle.
- R4: For a refused transfer, m_psel and m_penable stay low for the whole transfer, so the completer's state is not changed.
- R5: A refused transfer completes in its first access cycle with s_pready=1, s_pslverr=1 and s_prdata=0.
- R6: When s_pnse is held low, only mask bits 0 and 1 affect the decision. A region whose mask admits only Root and Realm refuses every transfer in that case.
- R7: The first refused setup sets `viol_flag` from the next cycle and captures that transfer's address and space. Later refusals leave the record unchanged. Reset clears the record.
- R8: Completer wait states on an admitted transfer stretch the upstream transfer cycle for cycle. The decision and forwarding hold until the completer signals ready.
- R9: On an admitted transfer, s_pslverr equals the completer's m_pslverr in access cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| allow_map | input | 4*2^REGION_BITS | Per-region allow masks |
| s_psel | input | 1 | Upstream select |
| s_penable | input | 1 | Upstream enable (access phase) |
| s_paddr | input | ADDR_W | Upstream address |
| s_pwrite | input | 1 | Upstream write flag |
| s_pwdata | input | DATA_W | Upstream write data |
| s_pprot | input | 3 | Upstream protection bits |
| s_pnse | input | 1 | Upstream address-space extension bit |
| s_pready | output | 1 | Upstream ready |
| s_prdata | output | DATA_W | Upstream read data |
| s_pslverr | output | 1 | Upstream error response |
| m_psel | output | 1 | Downstream select |
| m_penable | output | 1 | Downstream enable |
| m_paddr | output | ADDR_W | Downstream address |
| m_pwrite | output | 1 | Downstream write flag |
| m_pwdata | output | DATA_W | Downstream write data |
| m_pprot | output | 3 | Downstream protection bits |
| m_pready | input | 1 | Downstream ready |
| m_prdata | input | DATA_W | Downstream read data |
| m_pslverr | input | 1 | Downstream error response |
| viol_flag | output | 1 | Sticky refusal flag |
| viol_addr | output | ADDR_W | Address of first refused transfer |
| viol_space | output | 2 | Space code of first refused transfer |

## Verification
A wrong latched state shows up at the ports in the access cycle of the same transfer. A stale FWD state lets a refused access reach `m_psel`. A stale BLK state answers an admitted transfer with an error, or leaves `m_penable` low. The bench's reference model recomputes the decision from the allow map and the upstream bits on every clock and compares the select, enable, ready, error and data lines. A fault in the sticky record shows at `viol_flag`, `viol_addr` and `viol_space` one cycle after the setup edge that should or should not have set it. A second refusal exposes any overwrite.

// File: rtl/apb_world_pkg.sv
package apb_world_pkg;
    localparam int NUM_SPACES = 4;

    typedef enum logic [1:0] {
        SPACE_SECURE = 2'b00,
        SPACE_NONSEC = 2'b01,
        SPACE_ROOT   = 2'b10,
        SPACE_REALM  = 2'b11
    } space_e;

    typedef enum logic [1:0] {
        GATE_IDLE = 2'b00,
        GATE_FWD  = 2'b01,
        GATE_BLK  = 2'b10
    } gate_state_e;
endpackage

// File: rtl/apb_world_classify.sv
module apb_world_classify
    import apb_world_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int REGION_BITS = 2
) (
    input  logic [ADDR_W-1:0]                          paddr,
    input  logic                                       pnse,
    input  logic                                       pprot_ns,
    input  logic [NUM_SPACES*(2**REGION_BITS)-1:0]     allow_map,
    output space_e                                     space,
    output logic                                       allowed
);
    localparam int NUM_REGIONS = 2 ** REGION_BITS;

    logic [NUM_SPACES-1:0]  region_mask [NUM_REGIONS];
    logic [REGION_BITS-1:0] region;

    for (genvar g = 0; g < NUM_REGIONS; g++) begin : g_mask
        assign region_mask[g] = allow_map[g*NUM_SPACES +: NUM_SPACES];
    end

    always_comb begin
        space   = space_e'({pnse, pprot_ns});
        region  = paddr[ADDR_W-1 -: REGION_BITS];
        allowed = region_mask[region][space];
    end
endmodule

// File: rtl/apb_world_fsm.sv
module apb_world_fsm
    import apb_world_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              allowed,
    input  logic              s_psel,
    input  logic              s_penable,
    output logic              s_pready,
    output logic [DATA_W-1:0] s_prdata,
    output logic              s_pslverr,
    output logic              m_psel,
    output logic              m_penable,
    input  logic              m_pready,
    input  logic [DATA_W-1:0] m_prdata,
    input  logic              m_pslverr,
    output logic              trap_hit
);
    gate_state_e state, state_nx;

    always_comb begin
        state_nx = state;
        unique case (state)
            GATE_IDLE: if (s_psel && !s_penable) state_nx = allowed ? GATE_FWD : GATE_BLK;
            GATE_FWD:  if (!s_psel || (s_penable && m_pready)) state_nx = GATE_IDLE;
            GATE_BLK:  if (!s_psel || s_penable) state_nx = GATE_IDLE;
            default:   state_nx = GATE_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= GATE_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        m_psel    = 1'b0;
        m_penable = 1'b0;
        s_pready  = 1'b0;
        s_pslverr = 1'b0;
        s_prdata  = '0;
        trap_hit  = 1'b0;
        unique case (state)
            GATE_IDLE: begin
                m_psel   = s_psel && allowed;
                trap_hit = s_psel && !s_penable && !allowed;
            end
            GATE_FWD: begin
                m_psel    = s_psel;
                m_penable = s_psel && s_penable;
                s_pready  = m_pready;
                s_pslverr = m_pslverr;
                s_prdata  = m_prdata;
            end
            GATE_BLK: begin
                s_pready  = s_penable;
                s_pslverr = s_penable;
            end
            default: ;
        endcase
    end

    // R4
    blk_no_dsel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == GATE_BLK) |-> (!m_psel && !m_penable));

    // R5
    blk_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (s_psel && s_penable && !m_psel) |-> (s_pready && s_pslverr && s_prdata == '0));

    // R3
    en_has_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        m_penable |-> m_psel);

    // R8
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (m_penable && !m_pready && s_psel) |=> (state == GATE_FWD));
endmodule

// File: rtl/apb_world_trap.sv
module apb_world_trap
    import apb_world_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              trap_hit,
    input  logic [ADDR_W-1:0] paddr,
    input  space_e            space,
    output logic              viol_flag,
    output logic [ADDR_W-1:0] viol_addr,
    output logic [1:0]        viol_space
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            viol_flag  <= 1'b0;
            viol_addr  <= '0;
            viol_space <= '0;
        end else if (trap_hit && !viol_flag) begin
            viol_flag  <= 1'b1;
            viol_addr  <= paddr;
            viol_space <= space;
        end
    end

    // R7
    trap_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        viol_flag |=> (viol_flag && $stable(viol_addr) && $stable(viol_space)));
endmodule

// File: rtl/apb_world_gate.sv
module apb_world_gate
    import apb_world_pkg::*;
#(
    parameter int ADDR_W      = 16,
    parameter int DATA_W      = 32,
    parameter int REGION_BITS = 2
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [NUM_SPACES*(2**REGION_BITS)-1:0] allow_map,
    input  logic                                   s_psel,
    input  logic                                   s_penable,
    input  logic [ADDR_W-1:0]                      s_paddr,
    input  logic                                   s_pwrite,
    input  logic [DATA_W-1:0]                      s_pwdata,
    input  logic [2:0]                             s_pprot,
    input  logic                                   s_pnse,
    output logic                                   s_pready,
    output logic [DATA_W-1:0]                      s_prdata,
    output logic                                   s_pslverr,
    output logic                                   m_psel,
    output logic                                   m_penable,
    output logic [ADDR_W-1:0]                      m_paddr,
    output logic                                   m_pwrite,
    output logic [DATA_W-1:0]                      m_pwdata,
    output logic [2:0]                             m_pprot,
    input  logic                                   m_pready,
    input  logic [DATA_W-1:0]                      m_prdata,
    input  logic                                   m_pslverr,
    output logic                                   viol_flag,
    output logic [ADDR_W-1:0]                      viol_addr,
    output logic [1:0]                             viol_space
);
    space_e space;
    logic   allowed;
    logic   trap_hit;

    apb_world_classify #(.ADDR_W(ADDR_W), .REGION_BITS(REGION_BITS)) u_classify (
        .paddr(s_paddr), .pnse(s_pnse), .pprot_ns(s_pprot[1]),
        .allow_map(allow_map), .space(space), .allowed(allowed)
    );

    apb_world_fsm #(.DATA_W(DATA_W)) u_fsm (
        .clk(clk), .rst_n(rst_n), .allowed(allowed),
        .s_psel(s_psel), .s_penable(s_penable),
        .s_pready(s_pready), .s_prdata(s_prdata), .s_pslverr(s_pslverr),
        .m_psel(m_psel), .m_penable(m_penable),
        .m_pready(m_pready), .m_prdata(m_prdata), .m_pslverr(m_pslverr),
        .trap_hit(trap_hit)
    );

    apb_world_trap #(.ADDR_W(ADDR_W)) u_trap (
        .clk(clk), .rst_n(rst_n), .trap_hit(trap_hit), .paddr(s_paddr),
        .space(space), .viol_flag(viol_flag), .viol_addr(viol_addr),
        .viol_space(viol_space)
    );

    assign m_paddr  = s_paddr;
    assign m_pwrite = s_pwrite;
    assign m_pwdata = s_pwdata;
    assign m_pprot  = s_pprot;
endmodule

// File: tb/tb_apb_world_gate.sv
`timescale 1ns/1ps
module tb_apb_world_gate;
    localparam int AW = 16;
    localparam int DW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [15:0] allow_map;
    logic s_psel = 0, s_penable = 0, s_pwrite = 0, s_pnse = 0;
    logic [AW-1:0] s_paddr = '0;
    logic [DW-1:0] s_pwdata = '0;
    logic [2:0] s_pprot = '0;
    logic s_pready, s_pslverr, m_psel, m_penable, m_pwrite, m_pready, m_pslverr;
    logic [DW-1:0] s_prdata, m_pwdata, m_prdata;
    logic [AW-1:0] m_paddr, viol_addr;
    logic [2:0] m_pprot;
    logic viol_flag;
    logic [1:0] viol_space;

    always #5 clk = ~clk;

    apb_world_gate dut (.*);

    // completer model
    logic [DW-1:0] mem [16];
    logic [DW-1:0] shadow [16];
    logic [3:0] acc_cnt;
    logic [3:0] dn_wait = 0;
    logic dn_err = 0;
    always_comb begin
        m_pready  = m_psel && m_penable && (acc_cnt == dn_wait);
        m_pslverr = m_pready && dn_err;
        m_prdata  = mem[m_paddr[5:2]];
    end
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_cnt <= '0;
            for (int i = 0; i < 16; i++) mem[i] <= 32'hA000_0000 + i;
        end else begin
            acc_cnt <= (m_psel && m_penable && !m_pready) ? acc_cnt + 1'b1 : '0;
            if (m_pready && m_pwrite && !dn_err) mem[m_paddr[5:2]] <= m_pwdata;
        end
    end

    int total = 0, fails = 0, cyc = 0;

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic bit allow_of(input logic [AW-1:0] a, input logic nse, input logic ns);
        return allow_map[{a[AW-1:AW-2], nse, ns}];
    endfunction

    // reference model of the sticky record
    logic mflag = 0;
    logic [AW-1:0] maddr = '0;
    logic [1:0] mspace = '0;
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mflag = 0; maddr = '0; mspace = '0;
        end else if (s_psel && !s_penable && !allow_of(s_paddr, s_pnse, s_pprot[1]) && !mflag) begin
            mflag = 1; maddr = s_paddr; mspace = {s_pnse, s_pprot[1]};
        end
    end

    // per-clock comparison
    always @(negedge clk) begin
        if (rst_n) begin
            bit al;
            al = allow_of(s_paddr, s_pnse, s_pprot[1]);
            if (al) begin
                chk(m_psel == s_psel, "R3", "m_psel", m_psel, s_psel);
                chk(m_penable == (s_psel && s_penable), "R3", "m_penable", m_penable, s_psel && s_penable);
                if (m_psel)
                    chk(m_paddr == s_paddr && m_pwdata == s_pwdata && m_pprot == s_pprot && m_pwrite == s_pwrite,
                        "R3", "fwd fields", m_paddr, s_paddr);
                if (s_psel && s_penable) begin
                    chk(s_pready == m_pready, "R8", "s_pready", s_pready, m_pready);
                    chk(s_pslverr == m_pslverr, "R9", "s_pslverr", s_pslverr, m_pslverr);
                    if (!s_pwrite) chk(s_prdata == m_prdata, "R3", "s_prdata", s_prdata, m_prdata);
                end
            end else if (s_psel) begin
                chk(!m_psel && !m_penable, "R4", "m_psel on refused", m_psel, 0);
                if (s_penable)
                    chk(s_pready && s_pslverr && s_prdata == 0, "R5", "local response",
                        {s_pready, s_pslverr, s_prdata[29:0]}, 32'hC000_0000);
            end
            chk(viol_flag == mflag && viol_addr == maddr && viol_space == mspace, "R7", "sticky record",
                {viol_flag, viol_space, viol_addr}, {mflag, mspace, maddr});
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            fails++; total++;
            $display("FAIL watchdog: actual %0d expected <20000 cycles", cyc);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    task automatic xfer(input logic [AW-1:0] a, input logic wr, input logic [DW-1:0] wd,
                        input logic nse, input logic [2:0] prot, input int waits,
                        input logic derr, input string req);
        bit al;
        al = allow_of(a, nse, prot[1]);
        @(posedge clk); #1;
        dn_wait = waits[3:0]; dn_err = derr;
        s_psel = 1; s_penable = 0; s_paddr = a; s_pwrite = wr; s_pwdata = wd;
        s_pprot = prot; s_pnse = nse;
        @(posedge clk); #1;
        s_penable = 1;
        do @(negedge clk); while (!s_pready);
        chk(s_pslverr == (!al || derr), req, "error result", s_pslverr, !al || derr);
        if (!wr && !al) chk(s_prdata == 0, req, "refused rdata", s_prdata, 0);
        if (!wr && al && !derr) chk(s_prdata == shadow[a[5:2]], req, "read data", s_prdata, shadow[a[5:2]]);
        if (wr && al && !derr) shadow[a[5:2]] = wd;
        @(posedge clk); #1;
        s_psel = 0; s_penable = 0;
    endtask

    task automatic do_reset();
        rst_n = 0;
        for (int i = 0; i < 16; i++) shadow[i] = 32'hA000_0000 + i;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
    endtask

    initial begin
        // region0 all, region1 secure only, region2 nonsec+root, region3 root+realm
        allow_map = {4'b1100, 4'b0110, 4'b0001, 4'b1111};
        do_reset();
        @(negedge clk);
        chk(!viol_flag && !m_psel && viol_addr == 0, "R7", "reset state", {viol_flag, m_psel}, 0);

        xfer(16'h0004, 1, 32'h1111_0001, 0, 3'b000, 0, 0, "R3");
        xfer(16'h0004, 0, 0, 0, 3'b011, 0, 0, "R3");
        xfer(16'h0008, 1, 32'h2222_0002, 0, 3'b001, 2, 0, "R8");
        xfer(16'h0008, 0, 0, 1, 3'b010, 3, 0, "R8");
        xfer(16'h000C, 0, 0, 0, 3'b000, 1, 1, "R9");
        // refused nonsec write to region1; must not reach completer
        xfer(16'h4008, 1, 32'hDEAD_BEEF, 0, 3'b010, 0, 0, "R4");
        @(negedge clk);
        chk(viol_flag && viol_addr == 16'h4008 && viol_space == 2'b01, "R1", "first refusal",
            {viol_space, viol_addr}, {2'b01, 16'h4008});
        xfer(16'h0008, 0, 0, 0, 3'b000, 0, 0, "R4");
        xfer(16'h4010, 1, 32'h3333_0004, 0, 3'b000, 1, 0, "R6");
        xfer(16'h4010, 0, 0, 0, 3'b000, 0, 0, "R6");
        xfer(16'h4014, 0, 0, 1, 3'b011, 0, 0, "R5");
        @(negedge clk);
        chk(viol_addr == 16'h4008 && viol_space == 2'b01, "R7", "no overwrite",
            {viol_space, viol_addr}, {2'b01, 16'h4008});
        xfer(16'h8018, 1, 32'h4444_0006, 1, 3'b000, 0, 0, "R1");
        xfer(16'h8018, 0, 0, 0, 3'b010, 0, 0, "R2");
        xfer(16'h8018, 0, 0, 0, 3'b000, 0, 0, "R2");
        xfer(16'h8018, 0, 0, 1, 3'b010, 0, 0, "R1");
        xfer(16'hC01C, 1, 32'h5555_0007, 1, 3'b010, 0, 0, "R1");
        xfer(16'hC01C, 0, 0, 1, 3'b000, 2, 0, "R2");
        xfer(16'hC01C, 0, 0, 0, 3'b000, 0, 0, "R6");
        xfer(16'hC01C, 1, 32'h0BAD_0BAD, 0, 3'b011, 0, 0, "R6");
        allow_map[15:12] = 4'b0000;
        xfer(16'hC01C, 0, 0, 1, 3'b000, 0, 0, "R2");
        allow_map[15:12] = 4'b1100;
        xfer(16'h001C, 0, 0, 0, 3'b000, 0, 0, "R6");
        do_reset();
        @(negedge clk);
        chk(!viol_flag, "R7", "cleared by reset", viol_flag, 0);
        xfer(16'h4020, 0, 0, 1, 3'b010, 0, 0, "R5");
        @(negedge clk);
        chk(viol_flag && viol_addr == 16'h4020 && viol_space == 2'b11, "R1", "realm record",
            {viol_space, viol_addr}, {2'b11, 16'h4020});
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end
endmodule